// File: doc/BRIEF.md
# Epoch-Tagged Speculative Instruction Fetch

This block is the front end of a pipelined core whose instruction memory has a separate request channel and response channel. While the request channel accepts, the block sends one read per cycle at its current fetch address. It assumes the next instruction is sequential and advances the address by 4 after each accepted request. Each accepted request leaves a record in a small in-order tracking queue. The record holds the fetch address and a one-bit epoch tag taken at the moment of issue.

A redirect from later in the pipeline loads a new fetch address and flips the epoch bit. Requests already in the memory are not cancelled. Their responses still arrive in order, and the head of the tracking queue identifies each one. If a response's tag equals the current epoch, the instruction and its address go downstream over a valid/ready handshake. If the tag is stale, the response is popped and dropped with no downstream traffic. The memory side is a peek/pop interface: the block looks at the head response and asserts a pop strobe to consume it.

Top module: `epoch_fetch`

## Requirements
- R1: During reset and in the first cycle after it, `req_valid` is 1, `req_addr` equals `RESET_PC`, and `out_valid` and `rsp_pop` are 0.
- R2: In a cycle where `req_valid && req_ready` is 1 and `redir_valid` is 0, the next `req_addr` is the current one plus 4. If no request is accepted and there is no redirect, `req_addr` holds.
- R3: When `redir_valid` is 1, the next `req_addr` is `redir_pc`, whether or not a request is accepted in that cycle. A request accepted in the redirect cycle goes out at the old address with the old epoch, so its response is later dropped.
- R4: At most `DEPTH` requests are outstanding. With `DEPTH` outstanding, `req_valid` is 0 unless a response is popped in the same cycle, and in that case `req_valid` is 1.
- R5: When `rsp_valid` is 1 and the oldest outstanding request carries the current epoch, `out_valid` is 1, `out_instr` equals `rsp_data`, `out_pc` equals that request's address, and `rsp_pop` equals `out_ready`.
- R6: When `rsp_valid` is 1 and the oldest outstanding request carries a stale epoch, `out_valid` is 0 and `rsp_pop` is 1.
- R7: While `out_valid` is 1 and `out_ready` is 0, the response is not popped, and `out_pc` is unchanged in the next cycle.
- R8: `rsp_pop` is never 1 while `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Redirect strobe |
| redir_pc | input | AW | Redirect target address |
| req_valid | output | 1 | Fetch request valid |
| req_addr | output | AW | Fetch request address |
| req_ready | input | 1 | Memory accepts the request |
| rsp_valid | input | 1 | Head response present |
| rsp_data | input | IW | Head response instruction |
| rsp_pop | output | 1 | Consume the head response |
| out_valid | output | 1 | Instruction valid to decode |
| out_instr | output | IW | Instruction to decode |
| out_pc | output | AW | Address of the forwarded instruction |
| out_ready | input | 1 | Decode accepts the instruction |

## Verification
The bench builds the block with `DEPTH` of 4 and `RESET_PC` of 0x100. With a depth this small, a few cycles of withheld responses fill the tracking queue. That makes it easy to reach the full-queue stall and the case where a pop in the same cycle frees a slot. Because the reset address is nonzero, a design that resets the fetch address to zero is caught. The bench also fills the queue entirely with old-epoch entries and then redirects. The whole batch must then be dropped one response at a time before the new path reaches decode.

// File: rtl/epoch_fetch.sv
module epoch_fetch #(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int DEPTH = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_pc,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [IW-1:0] rsp_data,
  output logic          rsp_pop,
  output logic          out_valid,
  output logic [IW-1:0] out_instr,
  output logic [AW-1:0] out_pc,
  input  logic          out_ready
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    pc_r;
  logic             epoch_r;
  logic [AW-1:0]    trk_pc [DEPTH];
  logic [DEPTH-1:0] trk_ep;
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  logic head_live, hit, push;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_live = rsp_valid && (cnt != '0);
  assign hit       = (trk_ep[rp] == epoch_r);
  assign out_valid = head_live && hit;
  assign rsp_pop   = head_live && (!hit || out_ready);
  assign req_valid = (cnt != CW'(DEPTH)) || rsp_pop;
  assign push      = req_valid && req_ready;
  assign req_addr  = pc_r;
  assign out_pc    = trk_pc[rp];
  assign out_instr = rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_r    <= RESET_PC;
      epoch_r <= 1'b0;
    end else if (redir_valid) begin
      pc_r    <= redir_pc;
      epoch_r <= ~epoch_r;
    end else if (push) begin
      pc_r    <= pc_r + AW'(4);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      trk_ep <= '0;
    end else begin
      if (push) begin
        wp         <= bump(wp);
        trk_ep[wp] <= epoch_r;
      end
      if (rsp_pop) rp <= bump(rp);
      case ({push, rsp_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) trk_pc[wp] <= pc_r;
  end
endmodule

module epoch_fetch_chk #(
  parameter int AW = 32,
  parameter int DEPTH = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          redir_valid,
  input logic [AW-1:0] redir_pc,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_pop,
  input logic          out_valid,
  input logic [AW-1:0] out_pc,
  input logic          out_ready,
  input logic [CW-1:0] cnt
);
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !redir_valid |=> req_addr == $past(req_addr) + AW'(4));
  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) && !redir_valid |=> $stable(req_addr));
  // R3
  redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> req_addr == $past(redir_pc));
  // R4
  cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R4
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) && !rsp_pop |-> !req_valid);
  // R5
  fwd_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rsp_pop == out_ready);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_pc));
  // R8
  pop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pop |-> rsp_valid);
endmodule

bind epoch_fetch epoch_fetch_chk #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
  .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_pop(rsp_pop), .out_valid(out_valid),
  .out_pc(out_pc), .out_ready(out_ready), .cnt(cnt)
);

// File: tb/sim_epoch_fetch.sv
module sim_epoch_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam logic [31:0] RPC = 32'h100;
  // {target[63:32], len[31:24], out_ready mask[23:16], rsp mask[15:8], req_ready mask[7:0]}
  localparam logic [63:0] PH [7] = '{
    {32'h0,       8'd20, 8'hFF, 8'hFF, 8'hFF},
    {32'h0000400, 8'd16, 8'hFF, 8'hFF, 8'hFF},
    {32'h0,       8'd24, 8'hA5, 8'h77, 8'hDB},
    {32'h0001000, 8'd12, 8'h3C, 8'hFF, 8'hFF},
    {32'h0,       8'd30, 8'h55, 8'hEE, 8'hF0},
    {32'h0002000, 8'd10, 8'hFF, 8'h00, 8'hFF},
    {32'h0,       8'd30, 8'hFF, 8'hFF, 8'hFF}
  };

  logic clk = 0, rst_n = 0;
  logic redir_valid = 0, req_ready = 0, rsp_en = 0, out_ready = 0;
  logic [31:0] redir_pc = 0;
  logic req_valid, rsp_valid, rsp_pop, out_valid;
  logic [31:0] req_addr, rsp_data, out_instr, out_pc;

  logic [31:0] mq [32];
  int mh = 0, mt = 0, mc = 0;
  logic [31:0] tq_pc [32];
  logic tq_tag [32];
  int th = 0, tt = 0, tc = 0;
  logic [31:0] mpc = RPC;
  logic mep = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic cap_rv, cap_ov, cap_pop;
  logic [31:0] cap_opc;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] instr_of(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign rsp_valid = rsp_en && (mc > 0);
  assign rsp_data  = instr_of(mq[mh]);

  epoch_fetch #(.AW(32), .IW(32), .DEPTH(DEPTH), .RESET_PC(RPC)) u0 (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_pop(rsp_pop),
    .out_valid(out_valid), .out_instr(out_instr), .out_pc(out_pc),
    .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step(input logic rv, input logic [31:0] rt, input logic rqr, input logic rse, input logic ordy);
    logic hv, match, e_ov, e_pop, e_rv, fire, pop;
    logic [31:0] addr;
    @(negedge clk);
    redir_valid = rv; redir_pc = rt; req_ready = rqr; rsp_en = rse; out_ready = ordy;
    #1;
    hv = rsp_en && (mc > 0) && (tc > 0);
    match = hv && (tq_tag[th] == mep);
    e_ov = match;
    e_pop = hv && (!match || ordy);
    e_rv = (tc < DEPTH) || e_pop;
    chk(out_valid == e_ov, "R5/R6 out_valid", 64'(out_valid), 64'(e_ov));
    chk(rsp_pop == e_pop, "R5/R6 rsp_pop", 64'(rsp_pop), 64'(e_pop));
    if (e_ov) begin
      chk(out_pc == tq_pc[th], "R5 out_pc", 64'(out_pc), 64'(tq_pc[th]));
      chk(out_instr == instr_of(tq_pc[th]), "R5 out_instr", 64'(out_instr), 64'(instr_of(tq_pc[th])));
    end
    chk(req_valid == e_rv, "R4 req_valid", 64'(req_valid), 64'(e_rv));
    chk(req_addr == mpc, "R2 req_addr", 64'(req_addr), 64'(mpc));
    cap_rv = req_valid; cap_ov = out_valid; cap_pop = rsp_pop; cap_opc = out_pc;
    fire = req_valid && rqr;
    pop = rsp_pop;
    addr = req_addr;
    @(posedge clk);
    #1;
    if (pop) begin
      mh = (mh + 1) % 32; mc--;
      th = (th + 1) % 32; tc--;
    end
    if (fire) begin
      mq[mt] = addr; mt = (mt + 1) % 32; mc++;
      tq_pc[tt] = addr; tq_tag[tt] = mep; tt = (tt + 1) % 32; tc++;
    end
    if (rv) begin mpc = rt; mep = ~mep; end
    else if (fire) mpc = mpc + 4;
  endtask

  task automatic do_reset();
    rst_n = 0;
    redir_valid = 0; req_ready = 0; rsp_en = 0; out_ready = 0;
    mh = 0; mt = 0; mc = 0; th = 0; tt = 0; tc = 0; mpc = RPC; mep = 0;
    repeat (2) @(posedge clk);
    #1;
    chk(req_valid == 1'b1 && req_addr == RPC, "R1 reset request", 64'(req_addr), 64'(RPC));
    chk(out_valid == 0 && rsp_pop == 0, "R1 reset outputs", 64'({out_valid, rsp_pop}), 64'(0));
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    do_reset();
    // R1: first cycle after reset
    step(0, 0, 1, 1, 1);
    chk(cap_rv == 1'b1 && cap_ov == 1'b0, "R1 first cycle", 64'({cap_rv, cap_ov}), 64'(2));

    for (int p = 0; p < 7; p++) begin
      for (int i = 0; i < int'(PH[p][31:24]); i++) begin
        logic last;
        last = (i == int'(PH[p][31:24]) - 1) && (PH[p][63:32] != 0);
        step(last, PH[p][63:32], PH[p][i%8], PH[p][8+(i%8)], PH[p][16+(i%8)]);
      end
    end

    // drain everything
    repeat (12) step(0, 0, 0, 1, 1);

    // R4: fill the tracking queue with responses held back
    repeat (DEPTH) step(0, 0, 1, 0, 1);
    step(0, 0, 1, 0, 1);
    chk(cap_rv == 1'b0, "R4 full blocks request", 64'(cap_rv), 64'(0));
    step(0, 0, 1, 1, 1);
    chk(cap_rv == 1'b1 && cap_pop == 1'b1, "R4 pop frees slot", 64'({cap_rv, cap_pop}), 64'(3));

    // R7: downstream stall holds the head
    step(0, 0, 0, 1, 0);
    held = cap_opc;
    chk(cap_ov == 1'b1 && cap_pop == 1'b0, "R7 stall no pop", 64'({cap_ov, cap_pop}), 64'(2));
    step(0, 0, 0, 1, 0);
    chk(cap_opc == held && cap_pop == 1'b0, "R7 head held", 64'(cap_opc), 64'(held));
    step(0, 0, 0, 1, 1);
    chk(cap_opc == held && cap_pop == 1'b1, "R7 release", 64'(cap_opc), 64'(held));
    repeat (8) step(0, 0, 0, 1, 1);

    // R3: redirect in the same cycle as an accepted request
    step(1, 32'h3000, 1, 0, 1);
    chk(req_addr == 32'h3000, "R3 next address", 64'(req_addr), 64'h3000);
    step(0, 0, 0, 1, 1);
    chk(cap_ov == 1'b0 && cap_pop == 1'b1, "R3 R6 old-path dropped", 64'({cap_ov, cap_pop}), 64'(1));
    step(0, 0, 1, 1, 1);
    step(0, 0, 0, 1, 1);
    chk(cap_ov == 1'b1 && cap_opc == 32'h3000, "R3 R5 new path forwarded", 64'(cap_opc), 64'h3000);

    // R8: responses without a valid are never popped
    step(0, 0, 1, 0, 1);
    chk(cap_pop == 1'b0, "R8 no pop without response", 64'(cap_pop), 64'(0));
    repeat (6) step(0, 0, 1, 1, 1);

    // R1: reset again mid-traffic
    do_reset();
    step(0, 0, 1, 1, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule